// File: doc/BRIEF.md
# Gated Event Timestamper

This block stamps the rising edges on a set of event inputs with the value of a free-running counter and hands each result to the write side of an external FIFO. It records only while a gate input is high. Every gate window yields one packet: a start word when the gate opens, any number of event words, and a stop word when it closes. Each FIFO word is 34 bits: a 2-bit kind tag in bits 33:32 above a 32-bit payload.

The counter advances once per tick. The tick comes either from an internal divider that runs on the system clock, or from the rising edges of an external clock input that is brought in through a two-flop synchronizer and used as an enable. The gate and the event inputs are synchronized the same way. A parameter picks one of two variants. The single-channel variant writes a 32-bit stamp as the event payload. The eight-channel variant writes a channel-hit mask beside a 24-bit stamp. All channels that rose since the last tick are merged into one word.

When the FIFO reports full, words are dropped rather than stalled, and a sticky flag records the loss for the rest of that window. The reset input clears asynchronously and is released through a two-stage synchronizer.

Top module: `gated_tdc`

## Requirements
- R1: While rst_n is low, fifo_wr and overflow are 0.
- R2: Only tag values 01, 10 and 11 are ever written. Falling edges on the event inputs produce no word. Rising edges while the gate is closed produce no word.
- R3: A rising edge of gate_in produces one start word, tag 01, with payload 0. fifo_wr is high for that one cycle, after the third rising clock edge that follows the change of gate_in.
- R4: An event word has tag 10 and is written on a tick. In the eight-channel variant, payload bits 31:24 hold the mask of the channels that rose since the previous tick (bit i is channel i) and bits 23:0 hold the stamp value before that tick's increment. All such channels share one word. In the single-channel variant the payload is the 32-bit stamp.
- R5: A falling edge of gate_in produces one stop word, tag 11, whose payload is the stamp zero-extended to 32 bits. Edges that have not yet reached a tick when the gate closes are discarded, including edges seen in the same cycle as the close.
- R6: The stamp clears to 0 when the gate opens, adds 1 on each tick, and wraps at its width. The internal tick fires once every div_ratio clock cycles, with 0 treated as 1. The divider restarts when the gate opens, so that with ratio N the first tick comes N cycles after the open.
- R7: With ext_sel high, there is exactly one tick per synchronized rising edge of ext_clk, and the divider has no effect.
- R8: A word that would be written while fifo_full is high is not written, and overflow rises on the next cycle. overflow then stays high until the next gate open. At that open it is reloaded: it is 1 only if the start word itself was dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_ratio | input | DIV_W | Internal tick period in clock cycles (0 acts as 1) |
| ext_sel | input | 1 | 1 selects ext_clk rising edges as the tick |
| ext_clk | input | 1 | External tick clock, asynchronous |
| gate_in | input | 1 | Recording window, asynchronous |
| evt_in | input | NCH | Event inputs (8 or 1), asynchronous |
| fifo_full | input | 1 | FIFO full flag |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 34 | Tag in bits 33:32, payload in bits 31:0 |
| overflow | output | 1 | Sticky flag for words dropped in this window |

## Verification
The bench targets several edge cases. One is two channels rising in neighbouring cycles under a divided tick: a design that emits one word per edge instead of merging them would write extra event words. Another is an event edge that arrives in the same cycle the gate closes: a design that flushes pending hits would write an event word after the window, or alongside the stop word. The bench also runs an external tick, where a design that kept using the divider would return the wrong stop stamp. Finally it asserts full in the middle of a window: a leaky design would write while full, lose the flag when full drops, or keep the flag into the next packet.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  localparam int TAG_W  = 2;
  localparam int PAY_W  = 32;
  localparam int WORD_W = TAG_W + PAY_W;

  typedef enum logic [TAG_W-1:0] {
    TAG_NONE  = 2'b00,
    TAG_START = 2'b01,
    TAG_EVENT = 2'b10,
    TAG_STOP  = 2'b11
  } tdc_tag_e;
endpackage

// File: rtl/tdc_rst_sync.sv
module tdc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/tdc_sync.sv
// Two-flop synchronizer plus one history stage for edge detection.
module tdc_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] cur,
  output logic [W-1:0] prv
);
  logic [W-1:0] meta_q, cur_q, prv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prv_q  <= '0;
    end else begin
      meta_q <= d;
      cur_q  <= meta_q;
      prv_q  <= cur_q;
    end
  end

  assign cur = cur_q;
  assign prv = prv_q;
endmodule

// File: rtl/tdc_tick.sv
// Tick source: internal divider or synchronized external edge.
module tdc_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_ratio,
  input  logic             ext_sel,
  input  logic             ext_rise,
  output logic             tick
);
  logic [DIV_W-1:0] dcnt_q, dcnt_nx, ratio_eff;
  logic             int_tick;

  always_comb begin
    ratio_eff = (div_ratio == '0) ? DIV_W'(1) : div_ratio;
    int_tick  = (dcnt_q >= (ratio_eff - DIV_W'(1)));
    if (restart || int_tick) dcnt_nx = '0;
    else                     dcnt_nx = dcnt_q + DIV_W'(1);
    tick = ext_sel ? ext_rise : int_tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dcnt_q <= '0;
    else        dcnt_q <= dcnt_nx;
  end
endmodule

// File: rtl/tdc_stamp.sv
module tdc_stamp #(
  parameter int TS_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            tick,
  output logic [TS_W-1:0] stamp
);
  logic [TS_W-1:0] cnt_q, cnt_nx;
  logic            cnt_en;

  always_comb begin
    cnt_en = clear | tick;
    cnt_nx = clear ? '0 : cnt_q + TS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nx;
  end

  assign stamp = cnt_q;
endmodule

// File: rtl/tdc_framer.sv
// Builds start / event / stop words and drives the FIFO write port.
module tdc_framer
  import tdc_pkg::*;
#(
  parameter int MODEL = 1,
  parameter int NCH   = 8,
  parameter int TS_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_rise,
  input  logic              gate_fall,
  input  logic              tick,
  input  logic [NCH-1:0]    ch_rise,
  input  logic [TS_W-1:0]   stamp,
  input  logic              fifo_full,
  output logic              fifo_wr,
  output logic [WORD_W-1:0] fifo_wdata,
  output logic              overflow
);
  logic              open_q, open_nx;
  logic [NCH-1:0]    pend_q, pend_nx, hits;
  logic              ovf_q, ovf_nx;
  logic              wr_q, wr_nx;
  logic [WORD_W-1:0] word_q, word_nx;
  logic              want;
  tdc_tag_e          tag;
  logic [PAY_W-1:0]  pay, evt_pay, stamp_pay;

  assign stamp_pay = PAY_W'(stamp);

  generate
    if (MODEL == 1) begin : g_mask
      assign evt_pay = PAY_W'({hits, stamp});
    end else begin : g_single
      assign evt_pay = stamp_pay;
    end
  endgenerate

  always_comb begin
    hits    = pend_q | ch_rise;
    want    = 1'b0;
    tag     = TAG_NONE;
    pay     = '0;
    open_nx = open_q;
    pend_nx = pend_q;
    if (gate_rise) begin
      want    = 1'b1;
      tag     = TAG_START;
      open_nx = 1'b1;
      pend_nx = '0;
    end else if (gate_fall) begin
      want    = 1'b1;
      tag     = TAG_STOP;
      pay     = stamp_pay;
      open_nx = 1'b0;
      pend_nx = '0;
    end else if (open_q) begin
      if (tick && (hits != '0)) begin
        want    = 1'b1;
        tag     = TAG_EVENT;
        pay     = evt_pay;
        pend_nx = '0;
      end else begin
        pend_nx = hits;
      end
    end
    ovf_nx  = gate_rise ? (want & fifo_full) : (ovf_q | (want & fifo_full));
    wr_nx   = want & ~fifo_full;
    word_nx = {tag, pay};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      pend_q <= '0;
      ovf_q  <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      open_q <= open_nx;
      pend_q <= pend_nx;
      ovf_q  <= ovf_nx;
      wr_q   <= wr_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word_q <= '0;
    else if (wr_nx) word_q <= word_nx;
  end

  assign fifo_wr    = wr_q;
  assign fifo_wdata = word_q;
  assign overflow   = ovf_q;
endmodule

// File: rtl/gated_tdc.sv
module gated_tdc
  import tdc_pkg::*;
#(
  parameter  int MODEL = 1,
  parameter  int DIV_W = 16,
  localparam int NCH   = (MODEL == 1) ? 8 : 1,
  localparam int TS_W  = (MODEL == 1) ? 24 : 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_ratio,
  input  logic              ext_sel,
  input  logic              ext_clk,
  input  logic              gate_in,
  input  logic [NCH-1:0]    evt_in,
  input  logic              fifo_full,
  output logic              fifo_wr,
  output logic [WORD_W-1:0] fifo_wdata,
  output logic              overflow
);
  logic            rst_i;
  logic            gate_cur, gate_prv, ext_cur, ext_prv;
  logic [NCH-1:0]  evt_cur, evt_prv;
  logic            gate_rise, gate_fall, ext_rise, tick;
  logic [NCH-1:0]  ch_rise;
  logic [TS_W-1:0] stamp;

  tdc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_i));

  tdc_sync #(.W(1)) u_sync_gate (
    .clk(clk), .rst_n(rst_i), .d(gate_in), .cur(gate_cur), .prv(gate_prv));
  tdc_sync #(.W(1)) u_sync_ext (
    .clk(clk), .rst_n(rst_i), .d(ext_clk), .cur(ext_cur), .prv(ext_prv));
  tdc_sync #(.W(NCH)) u_sync_evt (
    .clk(clk), .rst_n(rst_i), .d(evt_in), .cur(evt_cur), .prv(evt_prv));

  assign gate_rise = gate_cur & ~gate_prv;
  assign gate_fall = ~gate_cur & gate_prv;
  assign ext_rise  = ext_cur & ~ext_prv;
  assign ch_rise   = evt_cur & ~evt_prv;

  tdc_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_i), .restart(gate_rise), .div_ratio(div_ratio),
    .ext_sel(ext_sel), .ext_rise(ext_rise), .tick(tick));

  tdc_stamp #(.TS_W(TS_W)) u_stamp (
    .clk(clk), .rst_n(rst_i), .clear(gate_rise), .tick(tick), .stamp(stamp));

  tdc_framer #(.MODEL(MODEL), .NCH(NCH), .TS_W(TS_W)) u_framer (
    .clk(clk), .rst_n(rst_i), .gate_rise(gate_rise), .gate_fall(gate_fall),
    .tick(tick), .ch_rise(ch_rise), .stamp(stamp), .fifo_full(fifo_full),
    .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .overflow(overflow));
endmodule

// File: rtl/tdc_checker.sv
module tdc_checker #(
  parameter int MODEL = 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        fifo_full,
  input logic        fifo_wr,
  input logic [33:0] fifo_wdata,
  input logic        overflow
);
  a_r2_tag_valid: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> (fifo_wdata[33:32] != 2'b00));

  a_r3_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && fifo_wdata[33:32] == 2'b01) |-> (fifo_wdata[31:0] == 32'd0));

  a_r4_event_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && fifo_wdata[33:32] == 2'b10) |-> ((MODEL != 1) || (fifo_wdata[31:24] != 8'd0)));

  a_r8_no_write_full: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> !$past(fifo_full));

  a_r8_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(fifo_full));

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(overflow) |-> (fifo_wr && fifo_wdata[33:32] == 2'b01));
endmodule

bind gated_tdc tdc_checker #(.MODEL(MODEL)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_full(fifo_full), .fifo_wr(fifo_wr),
  .fifo_wdata(fifo_wdata), .overflow(overflow));

// File: tb/sim_gated_tdc.sv
`timescale 1ns/1ps
module sim_gated_tdc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  div_ratio = 8'd1;
  logic        ext_sel = 1'b0, ext_clk = 1'b0, gate_in = 1'b0, fifo_full = 1'b0;
  logic [7:0]  evt_in = 8'h00;
  logic        fifo_wr, overflow;
  logic [33:0] fifo_wdata;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [33:0] log_q[$];

  always #2 clk = ~clk;

  gated_tdc #(.MODEL(1), .DIV_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .div_ratio(div_ratio), .ext_sel(ext_sel),
    .ext_clk(ext_clk), .gate_in(gate_in), .evt_in(evt_in), .fifo_full(fifo_full),
    .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .overflow(overflow));

  task automatic chk(input bit ok, input string req, input logic [33:0] act, input logic [33:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic string tag_req(input logic [1:0] t);
    case (t)
      2'b01:   return "R3";
      2'b10:   return "R4";
      2'b11:   return "R5";
      default: return "R2";
    endcase
  endfunction

  // Behavioural reference model
  logic        m_r1 = 0, m_r2 = 0;
  logic [2:0]  g_pipe = 0, e_pipe = 0;
  logic [7:0]  v1 = 0, v2 = 0, vp = 0;
  logic        m_open = 0, m_ovf = 0, exp_wr = 0, exp_ovf = 0;
  logic [7:0]  m_pend = 0;
  logic [23:0] m_cnt = 0;
  int          m_dc = 0;
  logic [33:0] exp_data = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_r1 = 0; m_r2 = 0;
      g_pipe = 0; e_pipe = 0; v1 = 0; v2 = 0; vp = 0;
      m_open = 0; m_ovf = 0; m_pend = 0; m_cnt = 0; m_dc = 0;
      exp_wr = 0; exp_ovf = 0;
    end else if (!m_r2) begin
      m_r2 = m_r1; m_r1 = 1;
    end else begin
      automatic bit gr = g_pipe[1] & ~g_pipe[2];
      automatic bit gf = ~g_pipe[1] & g_pipe[2];
      automatic bit er = e_pipe[1] & ~e_pipe[2];
      automatic logic [7:0] rise = v2 & ~vp;
      automatic int eff = (div_ratio == 0) ? 1 : int'(div_ratio);
      automatic bit itick = (m_dc >= eff - 1);
      automatic bit tk = ext_sel ? er : itick;
      automatic bit want = 0;
      automatic logic [33:0] w = 0;
      automatic logic [7:0] hits;
      if (gr) begin
        want = 1; w = {2'b01, 32'd0}; m_open = 1; m_pend = 0;
      end else if (gf) begin
        want = 1; w = {2'b11, 8'd0, m_cnt}; m_open = 0; m_pend = 0;
      end else if (m_open) begin
        hits = m_pend | rise;
        if (tk && hits != 0) begin
          want = 1; w = {2'b10, hits, m_cnt}; m_pend = 0;
        end else m_pend = hits;
      end
      if (gr) m_ovf = want & fifo_full;
      else    m_ovf = m_ovf | (want & fifo_full);
      exp_ovf = m_ovf;
      exp_wr  = want & ~fifo_full;
      if (exp_wr) exp_data = w;
      if (gr) m_cnt = 0; else if (tk) m_cnt = m_cnt + 1;
      m_dc = (gr || itick) ? 0 : m_dc + 1;
      g_pipe = {g_pipe[1:0], gate_in};
      e_pipe = {e_pipe[1:0], ext_clk};
      vp = v2; v2 = v1; v1 = evt_in;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk(fifo_wr == exp_wr, exp_wr ? tag_req(exp_data[33:32]) : "R2",
          {33'd0, fifo_wr}, {33'd0, exp_wr});
      if (exp_wr && fifo_wr)
        chk(fifo_wdata == exp_data, tag_req(exp_data[33:32]), fifo_wdata, exp_data);
      chk(overflow == exp_ovf, "R8", {33'd0, overflow}, {33'd0, exp_ovf});
      if (fifo_wr) log_q.push_back(fifo_wdata);
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [7:0] m);
    evt_in = m; wait_n(2); evt_in = 8'h00;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [7:0] mask_or;
    int nev;
    repeat (3) begin
      @(negedge clk);
      chk(fifo_wr == 1'b0 && overflow == 1'b0, "R1", {32'd0, fifo_wr, overflow}, 34'd0);
    end
    rst_n = 1'b1;
    wait_n(6);

    // Scenario: basic packet, falling edges and closed-gate edges ignored
    log_q.delete();
    div_ratio = 8'd1;
    pulse(8'h80); wait_n(6);
    gate_in = 1; wait_n(8);
    pulse(8'h01); wait_n(6);
    evt_in = 8'h28; wait_n(3); evt_in = 8'h00; wait_n(6);
    gate_in = 0; wait_n(8);
    pulse(8'h04); wait_n(6);
    chk(log_q.size() == 4, "R2", 34'(log_q.size()), 34'd4);
    if (log_q.size() == 4) begin
      chk(log_q[0] == {2'b01, 32'd0}, "R3", log_q[0], {2'b01, 32'd0});
      chk(log_q[1][33:24] == {2'b10, 8'h01}, "R4", log_q[1], {2'b10, 8'h01, 24'd0});
      chk(log_q[2][33:24] == {2'b10, 8'h28}, "R4", log_q[2], {2'b10, 8'h28, 24'd0});
      chk(log_q[3][33:32] == 2'b11, "R5", log_q[3], {2'b11, 32'd0});
      chk(log_q[2][23:0] > log_q[1][23:0], "R6", log_q[2], log_q[1]);
    end

    // Scenario: divided tick, neighbouring edges merge, stop stamp
    log_q.delete();
    div_ratio = 8'd4;
    gate_in = 1; wait_n(3);
    evt_in = 8'h02; wait_n(1);
    evt_in = 8'h06; wait_n(4);
    evt_in = 8'h00; wait_n(10);
    gate_in = 0; wait_n(8);
    mask_or = 0; nev = 0;
    foreach (log_q[i]) if (log_q[i][33:32] == 2'b10) begin
      mask_or |= log_q[i][31:24]; nev++;
    end
    chk(mask_or == 8'h06 && nev == 1, "R4", {26'd0, mask_or}, 34'h06);
    if (log_q.size() > 0)
      chk(log_q[log_q.size()-1] == {2'b11, 32'd4}, "R6", log_q[log_q.size()-1], {2'b11, 32'd4});

    // Scenario: external tick source
    log_q.delete();
    ext_sel = 1; div_ratio = 8'd1;
    gate_in = 1; wait_n(4);
    for (int k = 0; k < 5; k++) begin
      ext_clk = 1; wait_n(3); ext_clk = 0; wait_n(3);
      if (k == 1) evt_in = 8'h10;
    end
    evt_in = 8'h00; wait_n(4);
    gate_in = 0; wait_n(8);
    if (log_q.size() > 0)
      chk(log_q[log_q.size()-1] == {2'b11, 32'd5}, "R7", log_q[log_q.size()-1], {2'b11, 32'd5});
    chk(log_q.size() == 3, "R7", 34'(log_q.size()), 34'd3);
    ext_sel = 0;

    // Scenario: FIFO full drops words, sticky overflow
    log_q.delete();
    div_ratio = 8'd1;
    gate_in = 1; wait_n(6);
    fifo_full = 1; pulse(8'h01); wait_n(6);
    chk(overflow == 1'b1, "R8", {33'd0, overflow}, 34'd1);
    chk(log_q.size() == 1, "R8", 34'(log_q.size()), 34'd1);
    fifo_full = 0; wait_n(2);
    gate_in = 0; wait_n(8);
    chk(overflow == 1'b1, "R8", {33'd0, overflow}, 34'd1);
    chk(log_q.size() == 2 && log_q[log_q.size()-1][33:32] == 2'b11, "R8",
        34'(log_q.size()), 34'd2);
    gate_in = 1; wait_n(6);
    chk(overflow == 1'b0, "R8", {33'd0, overflow}, 34'd0);
    gate_in = 0; wait_n(8);

    // Scenario: edge in the closing cycle is discarded
    log_q.delete();
    div_ratio = 8'd16;
    gate_in = 1; wait_n(6);
    evt_in = 8'h01; gate_in = 0; wait_n(10);
    evt_in = 8'h00; wait_n(6);
    chk(log_q.size() == 2, "R5", 34'(log_q.size()), 34'd2);
    if (log_q.size() == 2)
      chk(log_q[1][33:32] == 2'b11, "R5", log_q[1], {2'b11, 32'd0});

    finish_run();
  end
endmodule